// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Controller

This block holds the cycle-by-cycle timing of a flyback converter that runs at the boundary between continuous and discontinuous conduction. It runs on one system clock and reads three comparator flags from the analog front end: the auxiliary-winding zero-crossing flag, the peak-current trip flag and the light-load skip flag. It produces one gate-enable bit for the external driver stage. A pulse starts when the transformer core has reset, which the block sees as a high-to-low transition of the zero-crossing flag. The pulse ends when the primary current reaches its setpoint.

Around that basic loop the block sets a minimum off-time after every turn-off, so the switching frequency has an upper bound and leakage ringing cannot retrigger a pulse. It blanks the current flag for a short time after turn-on, so the turn-on spike cannot end the pulse. When no core-reset edge arrives, a timeout restarts switching. While the skip flag is high, the turn-off input of the cycle latch is held active, so no pulse can start. All timing constants are parameters counted in clock cycles. The defaults assume a 50 MHz clock: 400 cycles of minimum off-time, 17 cycles of blanking and 250 cycles of timeout.

Top module: `qr_cycle_ctrl`

## Requirements
- R1: While rst_n is low, gate_out is 0. After rst_n is released, with en high and no falling edge on dmg_cmp, the first pulse starts exactly MIN_OFF+TIMEOUT (650) cycles later.
- R2: After every turn-off, gate_out stays low for at least MIN_OFF (400) cycles. A falling edge on dmg_cmp that would turn the gate on earlier than that is ignored.
- R3: The input ipk_cmp is 1 when the current setpoint is reached. Once blanking is over, a 1 on ipk_cmp turns gate_out off at the third rising clock edge after the input changes. Two of those cycles come from the synchronizer and one from the cycle latch.
- R4: A pulse lasts at least LEB (17) cycles, whatever ipk_cmp does during that time.
- R5: When the minimum off-time allows it, a 1-to-0 change of dmg_cmp turns gate_out on at the third rising edge after the change. A 0-to-1 change never turns the gate on.
- R6: If no edge is accepted, gate_out turns on exactly MIN_OFF+TIMEOUT (650) cycles after the turn-off.
- R7: skip_cmp is 1 while feedback is below the skip level. While it is high, the latch is held reset: a pulse in progress ends at the third edge after skip_cmp rises, and dmg_cmp edges and the timeout cannot start a pulse.
- R8: If the timeout has already expired when skip_cmp falls, a pulse starts at the third edge after the fall, with no dmg_cmp edge. If the timeout has not expired, the next accepted dmg_cmp edge or the timeout starts the pulse.
- R9: When en is 0, gate_out is 0 in the same cycle and the off-time and on-time counters are cleared. After en returns to 1, the timeout restart comes MIN_OFF+TIMEOUT cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Global run enable, synchronous to clk |
| dmg_cmp | input | 1 | Asynchronous auxiliary-winding zero-crossing flag (falling = core reset) |
| ipk_cmp | input | 1 | Asynchronous peak-current trip flag |
| skip_cmp | input | 1 | Asynchronous light-load skip flag |
| gate_out | output | 1 | Gate-drive enable |

## Verification
The checker tests four rules on every cycle:
- every rising edge of gate_out comes after at least MIN_OFF low cycles;
- the current flag cannot end a pulse inside the blanking window, and does end it after the window;
- a high skip flag leaves the latch reset on the next cycle;
- a low enable does the same.

The exact latencies of the accepted edges and the exact timeout restart are shown only by the bench scenarios. So are three other behaviours:
- the choice between restarting on skip release and waiting for an edge;
- ignoring edges during skip;
- the full timer re-arm after enable returns.

// File: rtl/qrc_pkg.sv
package qrc_pkg;

  typedef struct packed {
    logic dmg;
    logic ipk;
    logic skp;
  } cmp_t;

  function automatic int unsigned open_at(input int unsigned min_off);
    return (min_off > 0) ? min_off - 1 : 0;
  endfunction

  function automatic int unsigned restart_at(input int unsigned min_off, input int unsigned tmo);
    return (min_off + tmo > 0) ? min_off + tmo - 1 : 0;
  endfunction

  function automatic int unsigned blank_at(input int unsigned leb);
    return (leb > 0) ? leb - 1 : 0;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/qrc_sync.sv
module qrc_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i] <= '0;
      else        st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/qrc_satcnt.sv
module qrc_satcnt #(
  parameter int unsigned LIMIT = 1,
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (clr)       q <= '0;
    else if (q != TOP)  q <= q + 1'b1;
  end
endmodule

// File: rtl/qrc_latch.sv
module qrc_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic r_lvl,
  input  logic s_lvl,
  input  logic s_edge,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               q <= 1'b0;
    else if (r_lvl)           q <= 1'b0;
    else if (s_lvl || s_edge) q <= 1'b1;
  end
endmodule

// File: rtl/qr_cycle_ctrl.sv
module qr_cycle_ctrl
  import qrc_pkg::*;
#(
  parameter int unsigned MIN_OFF     = 400,
  parameter int unsigned LEB         = 17,
  parameter int unsigned TIMEOUT     = 250,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dmg_cmp,
  input  logic ipk_cmp,
  input  logic skip_cmp,
  output logic gate_out
);
  localparam int unsigned OPEN_AT    = open_at(MIN_OFF);
  localparam int unsigned RESTART_AT = restart_at(MIN_OFF, TIMEOUT);
  localparam int unsigned BLANK_AT   = blank_at(LEB);
  localparam int unsigned OW         = cnt_width(RESTART_AT);
  localparam int unsigned LW         = cnt_width(BLANK_AT);

  cmp_t raw, syn;
  logic dmg_s, ipk_s, skp_s, dmg_d;
  logic gate_q;
  logic [OW-1:0] off_cnt;
  logic [LW-1:0] on_cnt;

  // named internal events
  logic dmg_fall, win_open, tmo_hit, leb_done, ipk_rst, rst_lvl, set_edge;

  assign raw = '{dmg: dmg_cmp, ipk: ipk_cmp, skp: skip_cmp};

  qrc_sync #(.W($bits(cmp_t)), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  assign dmg_s = syn.dmg;
  assign ipk_s = syn.ipk;
  assign skp_s = syn.skp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dmg_d <= 1'b0;
    else        dmg_d <= dmg_s;
  end

  qrc_satcnt #(.LIMIT(RESTART_AT), .W(OW)) u_offcnt (
    .clk(clk), .rst_n(rst_n), .clr(gate_q | ~en), .q(off_cnt)
  );

  qrc_satcnt #(.LIMIT(BLANK_AT), .W(LW)) u_oncnt (
    .clk(clk), .rst_n(rst_n), .clr(~gate_q | ~en), .q(on_cnt)
  );

  assign dmg_fall = dmg_d & ~dmg_s;
  assign win_open = off_cnt >= OW'(OPEN_AT);
  assign tmo_hit  = off_cnt >= OW'(RESTART_AT);
  assign leb_done = on_cnt >= LW'(BLANK_AT);
  assign ipk_rst  = ipk_s & leb_done;
  assign rst_lvl  = ~en | skp_s | ipk_rst;
  assign set_edge = dmg_fall & win_open;

  qrc_latch u_latch (
    .clk(clk), .rst_n(rst_n),
    .r_lvl(rst_lvl), .s_lvl(tmo_hit), .s_edge(set_edge),
    .q(gate_q)
  );

  assign gate_out = gate_q & en;
endmodule

// File: rtl/qrc_chk.sv
module qrc_chk #(
  parameter int unsigned MIN_OFF = 400,
  parameter int unsigned LEB     = 17
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic gate_out,
  input logic gate_q,
  input logic skp_s,
  input logic ipk_s
);
  localparam int unsigned LOW_W = $clog2(MIN_OFF + 1);
  localparam int unsigned HI_W  = $clog2(LEB + 1);

  logic [LOW_W-1:0] lo_cnt;
  logic [HI_W-1:0]  hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lo_cnt <= '0;
    else if (gate_out)                   lo_cnt <= '0;
    else if (lo_cnt != LOW_W'(MIN_OFF))  lo_cnt <= lo_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     hi_cnt <= '0;
    else if (!gate_out)             hi_cnt <= '0;
    else if (hi_cnt != HI_W'(LEB))  hi_cnt <= hi_cnt + 1'b1;
  end

  assert_min_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_out && !$past(gate_out)) |-> (lo_cnt >= LOW_W'(MIN_OFF)))
    else $error("R2: pulse started before minimum off-time");

  assert_leb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_out && en && !skp_s && (hi_cnt < HI_W'(LEB - 1))) |=> gate_q)
    else $error("R4: pulse ended inside blanking window");

  assert_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && ipk_s && (hi_cnt >= HI_W'(LEB - 1))) |=> !gate_q)
    else $error("R3: current trip did not end pulse");

  assert_skip_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    skp_s |=> !gate_q)
    else $error("R7: latch set while skipping");

  assert_en_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !gate_q)
    else $error("R9: latch set while disabled");
endmodule

bind qr_cycle_ctrl qrc_chk #(.MIN_OFF(MIN_OFF), .LEB(LEB)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .gate_out(gate_out),
  .gate_q(gate_q), .skp_s(skp_s), .ipk_s(ipk_s)
);

// File: tb/sim_qr_cycle_ctrl.sv
module sim_qr_cycle_ctrl;
  localparam int CLK_PERIOD = 20;
  localparam int MIN_OFF = 400;
  localparam int LEB = 17;
  localparam int TMO = 250;
  localparam int NV = 8;
  // on phase: cycles until ipk raised; off phase: cycles until demag falls
  localparam int P_TAB [NV] = '{20, 0, 14, 5, 30, 2, 16, 40};
  localparam int D_TAB [NV] = '{397, 396, 10, 500, 646, 647, 700, 450};

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1;
  logic dmg = 1'b0, ipk = 1'b0, skp = 1'b0;
  logic gate_out;
  int total = 0, bad = 0;
  bit done = 1'b0;

  qr_cycle_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .dmg_cmp(dmg),
    .ipk_cmp(ipk), .skip_cmp(skp), .gate_out(gate_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_on(input int p);
    return (p + 3 > LEB) ? p + 3 : LEB;
  endfunction

  function automatic int exp_off(input int d);
    return (d + 3 >= MIN_OFF && d + 3 <= MIN_OFF + TMO) ? d + 3 : MIN_OFF + TMO;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_on(input int p, input int sk, output int len);
    int c = 0;
    dmg = 1'b1;
    while (gate_out && c < 5000) begin
      if (c == p) ipk = 1'b1;
      if (c == sk) skp = 1'b1;
      @(negedge clk);
      c++;
    end
    len = c;
  endtask

  task automatic run_off(input int d, input int skon, input int skoff, output int len);
    int c = 0;
    ipk = 1'b0;
    while (!gate_out && c < 5000) begin
      if (c == d) dmg = 1'b0;
      if (c == skon) skp = 1'b1;
      if (c == skoff) skp = 1'b0;
      @(negedge clk);
      c++;
    end
    len = c;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int len;
    int hi_seen;
    repeat (5) @(negedge clk);
    chk("R1 gate low in reset", int'(gate_out), 0);
    rst_n = 1'b1;
    run_off(-1, -1, -1, len);
    chk("R1/R6 first timeout pulse after reset", len, MIN_OFF + TMO);

    // table walk: one on phase then one off phase per entry
    for (int i = 0; i < NV; i++) begin
      run_on(P_TAB[i], -1, len);
      chk($sformatf("R3/R4 on length vec%0d", i), len, exp_on(P_TAB[i]));
      run_off(D_TAB[i], -1, -1, len);
      chk($sformatf("R2/R5/R6 off length vec%0d", i), len, exp_off(D_TAB[i]));
    end

    // R7: skip ends a pulse in progress
    run_on(-1, 30, len);
    chk("R7 skip terminates pulse", len, 33);
    // R7/R8: demag edge during skip ignored, release after timeout restarts
    run_off(450, -1, 800, len);
    chk("R8 release after timeout starts pulse", len, 803);
    run_on(10, -1, len);
    chk("R4 blanked pulse after skip", len, LEB);
    // R8: release before timeout waits for demag edge
    run_off(500, 0, 420, len);
    chk("R8 release before timeout waits edge", len, 503);

    // R9: enable low
    repeat (5) @(negedge clk);
    en = 1'b0;
    #1;
    chk("R9 gate low same cycle", int'(gate_out), 0);
    hi_seen = 0;
    for (int k = 0; k < 300; k++) begin
      if (k == 100) dmg = 1'b0;
      if (k == 150) dmg = 1'b1;
      @(negedge clk);
      if (gate_out) hi_seen++;
    end
    chk("R9 no pulse while disabled", hi_seen, 0);
    en = 1'b1;
    run_off(100, -1, -1, len);
    chk("R9 timers rearmed after enable", len, MIN_OFF + TMO);
    run_on(3, -1, len);
    chk("R3 trip at blanking end", len, LEB);

    finish_run();
  end
endmodule